// File: doc/BRIEF.md
# Tagged Memory-Fill Stage Engine

This block carries out one stage of a three-stage memory fill that also stamps allocation tags. A stage is a prologue, a main stage or an epilogue. It repeats one byte value across a destination region. For every 16-byte granule it fills, it also writes a 4-bit allocation tag. The surrounding pipeline gives it:

- a start strobe
- the stage code
- a scheme-select bit
- the destination-address register value
- the size register value
- the data word

When the stage ends, the block returns the updated register values, the condition flags and any fault.

There are two bookkeeping schemes.

- **Negative-count scheme.** The address register points one past the region. The size register holds minus the bytes still to fill.
- **Positive-count scheme.** The address register points at the next byte to fill. The size register holds a positive count.

The prologue does not fill any bytes. It saturates the size, checks alignment and converts the registers into the chosen scheme. The main and epilogue stages fill everything that remains.

Fill work goes out as chunks of at most 64 bytes. Each chunk is a request on a valid/ready data-write port.

- Once `wr_valid` is high, it stays high with an unchanged payload until `wr_ready` is seen.
- Only one chunk is outstanding at a time.
- The engine waits for exactly one `rsp_valid` pulse per accepted chunk. The response path has no back-pressure.

The tag-write port is a single-cycle strobe per granule.

Top module: `tms_fill_stage`

## Requirements
- R1: Every chunk request carries bits 7:0 of `data_in` on `wr_byte`. Bits 63:8 have no effect.
- R2: Each chunk length is the smaller of 64 and the remaining byte count, and is a nonzero multiple of 16. While `wr_valid` is high and `wr_ready` is low, the request payload holds steady.
- R3: After an accepted chunk succeeds, one tag is written per 16-byte granule of that chunk. Each tag value is bits 59:56 of the chunk's first address. The tag addresses run from the highest granule down to the lowest.
- R4: In the prologue (stage code 0) the size is unsigned. If its bit 63 is set, it is first clamped to 0x7FFFFFFFFFFFFFF0.
- R5: The prologue raises `align_fault` in either of two cases: the size is nonzero and address bits 3:0 are nonzero, or size bits 3:0 are nonzero. In that case `fault_addr` is the input address.
- R6: A prologue without a fault behaves as follows. Under the negative-count scheme (`opt_neg`=1) it outputs flags 0000, address plus size, and the negated size. Under the positive-count scheme it outputs flags 0010 (bit 1 set) and the address and size unchanged. It makes no data or tag writes.
- R7: In a main (code 1) or epilogue (code 2) stage under the negative-count scheme, each chunk goes to address plus size. The size rises by each chunk length until it reaches zero. The address output equals the address input. The flags are 0000.
- R8: In a main or epilogue stage under the positive-count scheme, each chunk goes to the address. After each chunk the address rises and the size falls by the chunk length, ending with size zero. The flags are 0010.
- R9: Suppose a response reports an error, or a byte count other than the chunk length. Then the stage ends with `wr_fault`, and the registers hold the progress of the earlier chunks. `fault_addr` is address plus size (negative-count scheme) or the address (positive-count scheme). No tags are written for that chunk.
- R10: A main or epilogue stage checks the alignment rule of R5. If it fails, the stage ends with `align_fault` and makes no writes. `fault_addr` is address plus size (negative-count scheme) or the address (positive-count scheme).
- R11: In main and epilogue stages the size is signed. A stage ends at once with no writes and with the registers unchanged when either holds:
  - the size is not positive under the positive-count scheme;
  - the size is not negative under the negative-count scheme.
- R12: `done` is a one-cycle pulse at the end of each stage. A `start` seen while `busy` is high is ignored. When the block is idle it drives neither `wr_valid` nor `tag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a stage (taken only when idle) |
| stage | input | 2 | 0 prologue, 1 main, 2 epilogue |
| opt_neg | input | 1 | 1 negative-count scheme, 0 positive-count scheme |
| addr_in | input | 64 | Destination-address register value |
| size_in | input | 64 | Size register value |
| data_in | input | 64 | Data word; low byte is the fill value |
| busy | output | 1 | Stage in progress |
| done | output | 1 | One-cycle end-of-stage pulse |
| addr_out | output | 64 | Updated address register |
| size_out | output | 64 | Updated size register |
| flags_out | output | 4 | Condition flags N,Z,C,V (bit 3 to bit 0) |
| align_fault | output | 1 | Alignment fault of the last stage |
| wr_fault | output | 1 | Write fault of the last stage |
| fault_addr | output | 64 | Faulting address |
| wr_valid | output | 1 | Chunk request valid |
| wr_ready | input | 1 | Chunk request accepted |
| wr_addr | output | 64 | Chunk start address |
| wr_len | output | 7 | Chunk length in bytes |
| wr_byte | output | 8 | Fill byte |
| rsp_valid | input | 1 | Chunk response strobe |
| rsp_count | input | 7 | Bytes reported written |
| rsp_err | input | 1 | Chunk response error |
| tag_we | output | 1 | Tag write strobe |
| tag_addr | output | 64 | Granule address for the tag |
| tag_val | output | 4 | Allocation tag value |

## Verification
Two things can land in the same cycle:

- a chunk request held back by a low `wr_ready`;
- a fresh `start` strobe from the pipeline while the engine is busy.

The bench provokes this by driving `wr_ready` from a random draw on every cycle. During a five-chunk stage it raises `start` again with a different stage code. The expected outcome is that the stray strobe changes nothing. The accepted chunk stream must match the model chunk by chunk, the held payload must not move, and the final address, size and flags must equal the values computed for the original stage alone.

// File: rtl/tms_pkg.sv
package tms_pkg;
  typedef enum logic [1:0] {
    STG_PRO  = 2'd0,
    STG_MAIN = 2'd1,
    STG_EPI  = 2'd2
  } stage_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_TAG,
    S_FIN
  } eng_st_e;

  localparam logic [3:0] FLAGS_NEG = 4'b0000;
  localparam logic [3:0] FLAGS_POS = 4'b0010;
endpackage

// File: rtl/tms_precond.sv
// Entry checks and prologue register conversion (combinational).
module tms_precond import tms_pkg::*; #(
  parameter int AW      = 64,
  parameter int GRAN_LG = 4
) (
  input  logic [1:0]    stage_i,
  input  logic          neg_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] size_o,
  output logic          misalign_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] nsize_o,
  output logic [3:0]    flags_o,
  output logic [AW-1:0] fault_addr_o
);
  localparam logic [AW-1:0] SAT = {1'b0, {(AW-1-GRAN_LG){1'b1}}, {GRAN_LG{1'b0}}};

  logic is_pro;

  always_comb begin
    is_pro       = (stage_i == STG_PRO);
    size_o       = (is_pro && size_i[AW-1]) ? SAT : size_i;
    misalign_o   = ((size_o != '0) && (addr_i[GRAN_LG-1:0] != '0)) ||
                   (size_o[GRAN_LG-1:0] != '0);
    addr_o       = neg_i ? (addr_i + size_o) : addr_i;
    nsize_o      = neg_i ? ('0 - size_o) : size_o;
    flags_o      = neg_i ? FLAGS_NEG : FLAGS_POS;
    fault_addr_o = (is_pro || !neg_i) ? addr_i : (addr_i + size_i);
  end
endmodule

// File: rtl/tms_chunk.sv
// Next-chunk geometry from the working registers (combinational).
module tms_chunk #(
  parameter int AW      = 64,
  parameter int CHUNK   = 64,
  parameter int TAG_LSB = 56,
  parameter int LW      = $clog2(CHUNK) + 1
) (
  input  logic          neg_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] size_i,
  output logic          more_o,
  output logic [LW-1:0] len_o,
  output logic [AW-1:0] caddr_o,
  output logic [3:0]    tag_o
);
  logic [AW-1:0] rem;

  always_comb begin
    rem     = neg_i ? ('0 - size_i) : size_i;
    more_o  = neg_i ? size_i[AW-1] : (!size_i[AW-1] && (size_i != '0));
    len_o   = (rem >= AW'(CHUNK)) ? LW'(CHUNK) : rem[LW-1:0];
    caddr_o = neg_i ? (addr_i + size_i) : addr_i;
    tag_o   = caddr_o[TAG_LSB+3:TAG_LSB];
  end
endmodule

// File: rtl/tms_tag_seq.sv
// Emits one tag write per granule, highest granule first.
module tms_tag_seq #(
  parameter int AW      = 64,
  parameter int LW      = 7,
  parameter int GRAN_LG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic [3:0]    tag_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [3:0]    tag_o,
  output logic          last_o
);
  logic [LW-1:0] cnt, cnt_m1;
  logic [AW-1:0] base_r;
  logic [3:0]    tag_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      base_r <= '0;
      tag_r  <= '0;
    end else if (load_i) begin
      cnt    <= len_i >> GRAN_LG;
      base_r <= base_i;
      tag_r  <= tag_i;
    end else if (cnt != '0) begin
      cnt <= cnt_m1;
    end
  end

  always_comb begin
    cnt_m1 = cnt - LW'(1);
    we_o   = (cnt != '0);
    addr_o = base_r + ({{(AW-LW){1'b0}}, cnt_m1} << GRAN_LG);
    tag_o  = tag_r;
    last_o = (cnt == LW'(1));
  end
endmodule

// File: rtl/tms_fill_stage.sv
module tms_fill_stage import tms_pkg::*; #(
  parameter int AW      = 64,
  parameter int CHUNK   = 64,
  parameter int GRAN_LG = 4,
  parameter int TAG_LSB = 56,
  parameter int LW      = $clog2(CHUNK) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    stage,
  input  logic          opt_neg,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] size_in,
  input  logic [63:0]   data_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] size_out,
  output logic [3:0]    flags_out,
  output logic          align_fault,
  output logic          wr_fault,
  output logic [AW-1:0] fault_addr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_len,
  output logic [7:0]    wr_byte,
  input  logic          rsp_valid,
  input  logic [LW-1:0] rsp_count,
  input  logic          rsp_err,
  output logic          tag_we,
  output logic [AW-1:0] tag_addr,
  output logic [3:0]    tag_val
);
  eng_st_e       st;
  logic [AW-1:0] a_r, s_r, fa_r;
  logic          neg_r, af_r, wf_r;
  logic [7:0]    byte_r;
  logic [3:0]    flags_r;

  logic [AW-1:0] pre_size, pre_addr, pre_nsize, pre_faddr;
  logic          pre_bad;
  logic [3:0]    pre_flags;

  logic          ck_more;
  logic [LW-1:0] ck_len;
  logic [AW-1:0] ck_addr, ck_len_w;
  logic [3:0]    ck_tag;

  logic          rsp_good, tag_ld, tag_last;

  tms_precond #(.AW(AW), .GRAN_LG(GRAN_LG)) u_pre (
    .stage_i(stage), .neg_i(opt_neg), .addr_i(addr_in), .size_i(size_in),
    .size_o(pre_size), .misalign_o(pre_bad), .addr_o(pre_addr),
    .nsize_o(pre_nsize), .flags_o(pre_flags), .fault_addr_o(pre_faddr)
  );

  tms_chunk #(.AW(AW), .CHUNK(CHUNK), .TAG_LSB(TAG_LSB), .LW(LW)) u_ck (
    .neg_i(neg_r), .addr_i(a_r), .size_i(s_r),
    .more_o(ck_more), .len_o(ck_len), .caddr_o(ck_addr), .tag_o(ck_tag)
  );

  tms_tag_seq #(.AW(AW), .LW(LW), .GRAN_LG(GRAN_LG)) u_tag (
    .clk(clk), .rst_n(rst_n), .load_i(tag_ld), .base_i(ck_addr),
    .len_i(ck_len), .tag_i(ck_tag), .we_o(tag_we), .addr_o(tag_addr),
    .tag_o(tag_val), .last_o(tag_last)
  );

  always_comb begin
    ck_len_w = {{(AW-LW){1'b0}}, ck_len};
    rsp_good = !rsp_err && (rsp_count == ck_len);
    tag_ld   = (st == S_RSP) && rsp_valid && rsp_good;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_r     <= '0;
      s_r     <= '0;
      fa_r    <= '0;
      neg_r   <= 1'b0;
      af_r    <= 1'b0;
      wf_r    <= 1'b0;
      byte_r  <= '0;
      flags_r <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          neg_r   <= opt_neg;
          byte_r  <= data_in[7:0];
          af_r    <= 1'b0;
          wf_r    <= 1'b0;
          fa_r    <= '0;
          flags_r <= pre_flags;
          if (pre_bad) begin
            af_r <= 1'b1;
            fa_r <= pre_faddr;
            a_r  <= addr_in;
            s_r  <= pre_size;
            st   <= S_FIN;
          end else if (stage == STG_PRO) begin
            a_r <= pre_addr;
            s_r <= pre_nsize;
            st  <= S_FIN;
          end else begin
            a_r <= addr_in;
            s_r <= size_in;
            st  <= S_REQ;
          end
        end
        S_REQ: begin
          if (!ck_more)      st <= S_FIN;
          else if (wr_ready) st <= S_RSP;
        end
        S_RSP: if (rsp_valid) begin
          if (rsp_good) begin
            st <= S_TAG;
          end else begin
            wf_r <= 1'b1;
            fa_r <= ck_addr;
            st   <= S_FIN;
          end
        end
        S_TAG: if (tag_last) begin
          if (neg_r) begin
            s_r <= s_r + ck_len_w;
          end else begin
            a_r <= a_r + ck_len_w;
            s_r <= s_r - ck_len_w;
          end
          st <= S_REQ;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (st != S_IDLE);
    done        = (st == S_FIN);
    addr_out    = a_r;
    size_out    = s_r;
    flags_out   = flags_r;
    align_fault = af_r;
    wr_fault    = wf_r;
    fault_addr  = fa_r;
    wr_valid    = (st == S_REQ) && ck_more;
    wr_addr     = ck_addr;
    wr_len      = ck_len;
    wr_byte     = byte_r;
  end
endmodule

// File: rtl/tms_fill_stage_chk.sv
module tms_fill_stage_chk #(
  parameter int AW    = 64,
  parameter int CHUNK = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          align_fault,
  input logic          wr_fault,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [LW-1:0] wr_len,
  input logic [7:0]    wr_byte,
  input logic          tag_we,
  input logic [AW-1:0] tag_addr,
  input logic [3:0]    tag_val
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(wr_byte));

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_len != '0) && (wr_len[3:0] == 4'd0) && (wr_len <= LW'(CHUNK)));

  p_tag_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we && $past(tag_we) |-> (tag_addr == $past(tag_addr) - AW'(16)) && (tag_val == $past(tag_val)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !tag_we);

  p_one_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(align_fault && wr_fault));

  p_align_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !wr_valid && !tag_we);
endmodule

bind tms_fill_stage tms_fill_stage_chk #(.AW(AW), .CHUNK(CHUNK), .LW(LW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .align_fault(align_fault),
  .wr_fault(wr_fault), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_len(wr_len), .wr_byte(wr_byte), .tag_we(tag_we), .tag_addr(tag_addr),
  .tag_val(tag_val)
);

// File: tb/sim_tms_fill_stage.sv
module sim_tms_fill_stage;
  localparam int LW = 7;
  localparam logic [63:0] SAT = 64'h7FFF_FFFF_FFFF_FFF0;

  logic        clk, rst_n, start, opt_neg;
  logic [1:0]  stage;
  logic [63:0] addr_in, size_in, data_in;
  logic        busy, done, align_fault, wr_fault;
  logic [63:0] addr_out, size_out, fault_addr;
  logic [3:0]  flags_out;
  logic        wr_valid, wr_ready, rsp_valid, rsp_err, tag_we;
  logic [63:0] wr_addr, tag_addr;
  logic [LW-1:0] wr_len, rsp_count;
  logic [7:0]  wr_byte;
  logic [3:0]  tag_val;

  tms_fill_stage u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stage(stage), .opt_neg(opt_neg),
    .addr_in(addr_in), .size_in(size_in), .data_in(data_in), .busy(busy),
    .done(done), .addr_out(addr_out), .size_out(size_out), .flags_out(flags_out),
    .align_fault(align_fault), .wr_fault(wr_fault), .fault_addr(fault_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_byte(wr_byte), .rsp_valid(rsp_valid), .rsp_count(rsp_count),
    .rsp_err(rsp_err), .tag_we(tag_we), .tag_addr(tag_addr), .tag_val(tag_val)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // model state
  logic        m_neg;
  logic [63:0] m_a, m_s, exp_taddr;
  logic [7:0]  m_byte;
  logic [3:0]  exp_tval;
  int          m_fault_k, chunk_idx, chunk_err, tag_err, tag_cnt, tags_left;
  bit          m_fault_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] f_min64(input logic [63:0] v);
    return (v >= 64'd64) ? 64'd64 : v;
  endfunction

  // memory-port responder and chunk checker
  initial begin
    bit          pending = 1'b0;
    logic [LW-1:0] p_count = '0;
    bit          p_err = 1'b0;
    logic [63:0] cur, rem, len;
    wr_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_count = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
      if (pending) begin
        rsp_valid = 1'b1; rsp_count = p_count; rsp_err = p_err; pending = 1'b0;
      end
      wr_ready = ($urandom % 4) != 0;
      #1;
      if (wr_valid && wr_ready) begin
        cur = m_neg ? m_a + m_s : m_a;
        rem = m_neg ? 64'd0 - m_s : m_s;
        len = f_min64(rem);
        if (len == 0 || wr_addr != cur || 64'(wr_len) != len || wr_byte != m_byte)
          chunk_err++;
        exp_taddr = cur + len - 64'd16;
        exp_tval  = cur[59:56];
        tags_left = int'(len / 16);
        pending   = 1'b1;
        if (chunk_idx == m_fault_k) begin
          p_count = m_fault_err ? len[LW-1:0] : len[LW-1:0] - LW'(16);
          p_err   = m_fault_err;
        end else begin
          p_count = len[LW-1:0];
          p_err   = 1'b0;
          if (m_neg) m_s = m_s + len;
          else begin m_a = m_a + len; m_s = m_s - len; end
        end
        chunk_idx++;
      end
    end
  end

  // tag monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (tag_we) begin
        tag_cnt++;
        if (tags_left == 0 || tag_addr != exp_taddr || tag_val != exp_tval) tag_err++;
        else begin exp_taddr = exp_taddr - 64'd16; tags_left--; end
      end
    end
  end

  task automatic do_op(input logic [1:0] stg, input bit neg, input logic [63:0] a,
                       input logic [63:0] s, input logic [63:0] d, input int fk,
                       input bit ferr, input bit poke);
    int t = 0;
    m_neg = neg; m_a = a; m_s = s; m_byte = d[7:0];
    m_fault_k = fk; m_fault_err = ferr;
    chunk_idx = 0; chunk_err = 0; tag_err = 0; tag_cnt = 0; tags_left = 0;
    @(negedge clk);
    stage = stg; opt_neg = neg; addr_in = a; size_in = s; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 2) begin
        start = 1'b1; stage = 2'd0; opt_neg = ~neg; addr_in = 64'h8; size_in = 64'h30;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(done == 1'b1, "R12", "done reached", 64'(done), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual %h expected %h", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] a, s, d, a2, s2;
    bit neg;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; stage = 2'd0; opt_neg = 1'b0;
    addr_in = '0; size_in = '0; data_in = '0;
    m_neg = 0; m_a = 0; m_s = 0; m_byte = 0; m_fault_k = -1; m_fault_err = 0;
    chunk_idx = 0; chunk_err = 0; tag_err = 0; tag_cnt = 0; tags_left = 0;
    exp_taddr = 0; exp_tval = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid && !tag_we && !align_fault && !wr_fault,
        "R12", "reset idle", {busy, done, wr_valid, tag_we}, 64'd0);

    // random chained prologue + main/epilogue
    for (int i = 0; i < 24; i++) begin
      neg = $urandom % 2;
      a = {$urandom, $urandom} & ~64'hF;
      s = 64'(($urandom % 41) * 16);
      d = {$urandom, $urandom};
      do_op(2'd0, neg, a, s, d, -1, 0, 0);
      a2 = neg ? a + s : a;
      s2 = neg ? 64'd0 - s : s;
      chk(addr_out == a2, "R6", "prologue addr", addr_out, a2);
      chk(size_out == s2, "R6", "prologue size", size_out, s2);
      chk(flags_out == (neg ? 4'b0000 : 4'b0010), "R6", "prologue flags",
          64'(flags_out), neg ? 64'd0 : 64'd2);
      chk(chunk_idx == 0 && tag_cnt == 0 && !align_fault, "R6", "prologue no writes",
          64'(chunk_idx + tag_cnt), 64'd0);
      do_op(($urandom % 2) ? 2'd1 : 2'd2, neg, a2, s2, d, -1, 0, 0);
      chk(size_out == 64'd0, neg ? "R7" : "R8", "final size", size_out, 64'd0);
      chk(addr_out == (neg ? a2 : a + s), neg ? "R7" : "R8", "final addr",
          addr_out, neg ? a2 : a + s);
      chk(flags_out == (neg ? 4'b0000 : 4'b0010), neg ? "R7" : "R8", "stage flags",
          64'(flags_out), neg ? 64'd0 : 64'd2);
      chk(chunk_err == 0, "R1 R2", "chunk addr/len/byte", 64'(chunk_err), 64'd0);
      chk(tag_err == 0 && tag_cnt == int'(s / 16), "R3", "tag stream",
          64'(tag_cnt), s / 16);
      chk(!wr_fault && !align_fault, "R9", "no fault", 64'(wr_fault), 64'd0);
    end

    // R4 saturation
    do_op(2'd0, 0, 64'h100, 64'h8000_0000_0000_0020, 64'h11, -1, 0, 0);
    chk(size_out == SAT && addr_out == 64'h100 && flags_out == 4'b0010, "R4",
        "pos saturation", size_out, SAT);
    do_op(2'd0, 1, 64'h100, 64'hFFFF_FFFF_FFFF_FFF0, 64'h11, -1, 0, 0);
    chk(size_out == 64'd0 - SAT && addr_out == 64'h100 + SAT, "R4",
        "neg saturation", size_out, 64'd0 - SAT);

    // R5 prologue alignment
    do_op(2'd0, 0, 64'h108, 64'h20, 64'h0, -1, 0, 0);
    chk(align_fault && fault_addr == 64'h108, "R5", "misaligned addr", fault_addr, 64'h108);
    do_op(2'd0, 1, 64'h108, 64'h0, 64'h0, -1, 0, 0);
    chk(!align_fault, "R5", "zero size any addr", 64'(align_fault), 64'd0);
    do_op(2'd0, 0, 64'h100, 64'h18, 64'h0, -1, 0, 0);
    chk(align_fault && fault_addr == 64'h100, "R5", "misaligned size", fault_addr, 64'h100);

    // R10 stage alignment
    do_op(2'd1, 0, 64'h200, 64'h28, 64'h0, -1, 0, 0);
    chk(align_fault && fault_addr == 64'h200 && chunk_idx == 0 && tag_cnt == 0, "R10",
        "pos stage misaligned size", fault_addr, 64'h200);
    do_op(2'd2, 1, 64'h204, 64'd0 - 64'h40, 64'h0, -1, 0, 0);
    chk(align_fault && fault_addr == 64'h1C4 && chunk_idx == 0 && tag_cnt == 0, "R10",
        "neg stage misaligned addr", fault_addr, 64'h1C4);

    // R11 signed size with nothing to do
    do_op(2'd1, 0, 64'h300, 64'd0 - 64'd32, 64'h0, -1, 0, 0);
    chk(!align_fault && size_out == 64'd0 - 64'd32 && chunk_idx == 0, "R11",
        "pos negative size", size_out, 64'd0 - 64'd32);
    do_op(2'd2, 1, 64'h300, 64'd48, 64'h0, -1, 0, 0);
    chk(!align_fault && size_out == 64'd48 && addr_out == 64'h300 && chunk_idx == 0,
        "R11", "neg positive size", size_out, 64'd48);

    // R9 write faults
    do_op(2'd1, 0, 64'h1000, 64'd256, 64'h5A, 1, 0, 0);
    chk(wr_fault && addr_out == 64'h1040 && size_out == 64'd192, "R9",
        "pos short count regs", size_out, 64'd192);
    chk(fault_addr == 64'h1040 && tag_cnt == 4, "R9", "pos fault addr", fault_addr, 64'h1040);
    do_op(2'd2, 1, 64'h3100, 64'd0 - 64'd256, 64'hA5, 2, 1, 0);
    chk(wr_fault && addr_out == 64'h3100 && size_out == 64'd0 - 64'd128, "R9",
        "neg error regs", size_out, 64'd0 - 64'd128);
    chk(fault_addr == 64'h3080 && tag_cnt == 8, "R9", "neg fault addr", fault_addr, 64'h3080);

    // R12 start while busy, R1 upper data bits
    do_op(2'd1, 0, 64'h0F00_0000_0000_5000, 64'd320, 64'hDEAD_BEEF_0000_77C3, -1, 0, 1);
    chk(chunk_err == 0 && chunk_idx == 5, "R12", "start while busy ignored",
        64'(chunk_idx), 64'd5);
    chk(size_out == 0 && addr_out == 64'h0F00_0000_0000_5140, "R12", "regs after poke",
        addr_out, 64'h0F00_0000_0000_5140);

    // R2 remainder chunk
    do_op(2'd2, 0, 64'h6000, 64'h70, 64'h1, -1, 0, 0);
    chk(chunk_idx == 2 && chunk_err == 0 && tag_cnt == 7, "R2", "64+48 split",
        64'(chunk_idx), 64'd2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule